// File: doc/BRIEF.md
# Programming Cycle Timer and Acknowledge Polling Controller

This block belongs to a two-wire serial memory device. It takes over once a page write has been committed by the stop condition that ends the write transfer. It copies the bytes held in the page buffer into the array, one per system clock, and then waits out the remainder of a fixed programming window. During that whole window it reports the device as busy. It also tells the protocol engine not to acknowledge an incoming device address word, so that a host can poll for readiness by repeating that word until it is acknowledged.

The block also keeps the address used by current-address reads. That address follows two different wrap rules. After a read it moves to the byte after the last one read, and it wraps from the top of the array to zero. After a write it moves to the byte after the last one written, but it stays inside that page. A random read's dummy write loads the address directly. Any request that arrives while the programming window is open is dropped.

Top module: `wcycle_poll_ctrl`

## Requirements
- R1: A `commit_req` pulse that is sampled while `busy` is low makes `busy` high from the next clock onward.
- R2: Once started, `busy` stays high for exactly `CYCLE_CLKS` clocks and then returns low (the effective length is never less than page size plus one).
- R3: `ack_en` is 0 on every clock where `busy` is 1, and 1 on every clock where `busy` is 0.
- R4: In clock k (k = 0 .. 2^PAGE_W-1) of a cycle, and only then, `mem_we` is high exactly when bit k of the committed mask is 1. In that clock, `mem_addr` = {page of `commit_last`, k} and `mem_wdata` is the buffer byte at offset k (`buf_rd_idx` = k). `mem_we` is never high outside a cycle.
- R5: A `commit_req` sampled while `busy` is high has no effect. It starts no new cycle, makes no extra array writes and does not change `cur_addr`.
- R6: A `rd_done` sampled while idle sets `cur_addr` to (`rd_addr` + 1) modulo 2^ADDR_W, so the top address wraps to 0.
- R7: An accepted commit sets `cur_addr` to the page of `commit_last` joined with (offset of `commit_last` + 1) modulo 2^PAGE_W, so the last byte of a page wraps to the first byte of the same page.
- R8: An `addr_load` sampled while idle sets `cur_addr` to `addr_load_val`. When requests arrive together, the order of precedence is: commit first, then `addr_load`, then `rd_done`.
- R9: `rd_done` and `addr_load` sampled while `busy` is high leave `cur_addr` unchanged.
- R10: After reset, `busy` = 0, `ack_en` = 1, `mem_we` = 0 and `cur_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| commit_req | input | 1 | Stop condition after a write: start the programming cycle |
| commit_last | input | ADDR_W | Address of the last byte written; its upper bits name the page |
| commit_mask | input | 2^PAGE_W | One bit per page offset that holds new data |
| buf_rd_idx | output | PAGE_W | Page buffer read offset |
| buf_rd_data | input | DATA_W | Page buffer byte at `buf_rd_idx` |
| addr_load | input | 1 | Dummy write finished: load the current address |
| addr_load_val | input | ADDR_W | Address to load |
| rd_done | input | 1 | A read byte was transferred |
| rd_addr | input | ADDR_W | Address of the byte just read |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Programming cycle in progress |
| ack_en | output | 1 | Device address word may be acknowledged |
| cur_addr | output | ADDR_W | Current-address read pointer |

## Verification
The hardest case to reach is a request that lands inside the programming window, such as a second commit, a read completion or an address load. It can only be tested by timing it against an internal cycle that is long and otherwise invisible. The bench uses a short cycle length. It injects these requests a few clocks after a commit and checks that the cycle length, the set of writes and `cur_addr` all stay as they were. Random pages, masks and buffer contents are mixed with directed cases at the wrap points: an end-of-page write, a read of the top address and an empty mask.

// File: rtl/wcycle_pkg.sv
package wcycle_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_e;
endpackage

// File: rtl/wcycle_timer.sv
module wcycle_timer #(
  parameter int unsigned CYCLE_CLKS = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  import wcycle_pkg::*;
  localparam int unsigned CW = $clog2(CYCLE_CLKS + 1);

  phase_e          ph_q;
  logic [CW-1:0]   cnt_q;

  assign busy = (ph_q == PH_RUN);
  assign done = busy && (cnt_q == CW'(CYCLE_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start) begin
          ph_q  <= PH_RUN;
          cnt_q <= '0;
        end
        PH_RUN: begin
          if (done) ph_q <= PH_IDLE;
          else      cnt_q <= cnt_q + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R1: an idle start opens the window on the next clock
  a_r1_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
endmodule

// File: rtl/wcycle_page_seq.sv
module wcycle_page_seq #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PAGE_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-PAGE_W-1:0] start_page,
  input  logic [(1<<PAGE_W)-1:0]   start_mask,
  output logic [PAGE_W-1:0]        buf_rd_idx,
  input  logic [DATA_W-1:0]        buf_rd_data,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic                     active
);
  localparam int unsigned PB = 1 << PAGE_W;

  logic [PAGE_W-1:0]        idx_q;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic [PB-1:0]            mask_q;

  assign buf_rd_idx = idx_q;
  assign mem_we     = active && mask_q[idx_q];
  assign mem_addr   = {page_q, idx_q};
  assign mem_wdata  = buf_rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx_q  <= '0;
      page_q <= '0;
      mask_q <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      idx_q  <= '0;
      page_q <= start_page;
      mask_q <= start_mask;
    end else if (active) begin
      if (idx_q == PAGE_W'(PB - 1)) active <= 1'b0;
      else                          idx_q  <= idx_q + 1'b1;
    end
  end

  // R4: the byte offset walks forward by one per clock while copying
  a_r4_offset_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && idx_q != PAGE_W'(PB - 1)) |=> (active && idx_q != '0));
endmodule

// File: rtl/wcycle_addr_track.sv
module wcycle_addr_track #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              commit_acc,
  input  logic [ADDR_W-1:0] commit_last,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_load_val,
  input  logic              rd_done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  // after a read: linear step through the whole array
  function automatic logic [ADDR_W-1:0] step_after_read(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  // after a write: offset steps, page bits are held
  function automatic logic [ADDR_W-1:0] step_after_write(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] off;
    off = a[PAGE_W-1:0] + 1'b1;
    return {a[ADDR_W-1:PAGE_W], off};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
    end else if (!busy) begin
      if (commit_acc)     cur_addr <= step_after_write(commit_last);
      else if (addr_load) cur_addr <= addr_load_val;
      else if (rd_done)   cur_addr <= step_after_read(rd_addr);
    end
  end

  // R9: nothing moves the pointer inside the programming window
  a_r9_hold_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_addr));
  // R6: reading the top location wraps the pointer to zero
  a_r6_read_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !commit_acc && !addr_load && rd_done && (&rd_addr)) |=> (cur_addr == '0));
  // R7: writing the last byte of a page returns to that page's first byte
  a_r7_write_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_acc && (&commit_last[PAGE_W-1:0])) |=>
      (cur_addr[PAGE_W-1:0] == '0 && cur_addr[ADDR_W-1:PAGE_W] == $past(commit_last[ADDR_W-1:PAGE_W])));
endmodule

// File: rtl/wcycle_poll_ctrl.sv
module wcycle_poll_ctrl #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned PAGE_W     = 5,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CYCLE_CLKS = 250000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit_req,
  input  logic [ADDR_W-1:0]      commit_last,
  input  logic [(1<<PAGE_W)-1:0] commit_mask,
  output logic [PAGE_W-1:0]      buf_rd_idx,
  input  logic [DATA_W-1:0]      buf_rd_data,
  input  logic                   addr_load,
  input  logic [ADDR_W-1:0]      addr_load_val,
  input  logic                   rd_done,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  output logic                   busy,
  output logic                   ack_en,
  output logic [ADDR_W-1:0]      cur_addr
);
  localparam int unsigned PB      = 1 << PAGE_W;
  localparam int unsigned CYC_EFF = (CYCLE_CLKS > PB) ? CYCLE_CLKS : PB + 1;
  localparam int unsigned LW      = $clog2(CYC_EFF + 2);

  logic commit_acc;
  logic timer_done;
  logic prog_active;

  assign commit_acc = commit_req && !busy;
  assign ack_en     = !busy;

  wcycle_timer #(.CYCLE_CLKS(CYC_EFF)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(commit_acc), .busy(busy), .done(timer_done)
  );

  wcycle_page_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(commit_acc),
    .start_page(commit_last[ADDR_W-1:PAGE_W]), .start_mask(commit_mask),
    .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .active(prog_active)
  );

  wcycle_addr_track #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) trk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .commit_acc(commit_acc),
    .commit_last(commit_last), .addr_load(addr_load), .addr_load_val(addr_load_val),
    .rd_done(rd_done), .rd_addr(rd_addr), .cur_addr(cur_addr)
  );

  // checker state: length of the current busy window
  logic [LW-1:0] busy_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len_q <= '0;
    else if (busy) busy_len_q <= busy_len_q + 1'b1;
    else           busy_len_q <= '0;
  end

  // R2: every window lasts exactly the configured number of clocks
  a_r2_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len_q == LW'(CYC_EFF)));
  // R4: array strobes only inside the window
  a_r4_we_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R4: copying is finished before the window closes
  a_r4_copy_before_end: assert property (@(posedge clk) disable iff (!rst_n)
    timer_done |-> !prog_active);
  // R5: a commit during the window does not restart copying
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && commit_req && !prog_active) |=> !prog_active);
  // R3: polling sees no acknowledge while programming
  a_r3_ack_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !ack_en);
endmodule

// File: tb/wcycle_poll_ctrl_tb.sv
module wcycle_poll_ctrl_tb_top;
  localparam int AW = 12, PW = 5, DW = 8, CYC = 40, PB = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic commit_req = 0, addr_load = 0, rd_done = 0;
  logic [AW-1:0] commit_last = '0, addr_load_val = '0, rd_addr = '0;
  logic [PB-1:0] commit_mask = '0;
  logic [PW-1:0] buf_rd_idx;
  logic [DW-1:0] buf_rd_data;
  logic mem_we, busy, ack_en;
  logic [AW-1:0] mem_addr, cur_addr;
  logic [DW-1:0] mem_wdata;

  bit [7:0] pbuf [PB];
  bit [7:0] got_mem [4096];
  bit [7:0] exp_mem [4096];
  int checks = 0, fails = 0;
  bit [AW-1:0] exp_cur = '0;

  assign buf_rd_data = pbuf[buf_rd_idx];
  always #10 clk = ~clk;

  wcycle_poll_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .CYCLE_CLKS(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .commit_last(commit_last),
    .commit_mask(commit_mask), .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data),
    .addr_load(addr_load), .addr_load_val(addr_load_val), .rd_done(rd_done),
    .rd_addr(rd_addr), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .ack_en(ack_en), .cur_addr(cur_addr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [AW-1:0] exp_after_read(input bit [AW-1:0] a);
    return (a + 1) % 4096;
  endfunction
  function automatic bit [AW-1:0] exp_after_write(input bit [AW-1:0] a);
    return (a & ~12'd31) | ((a % 32 + 1) % 32);
  endfunction

  task automatic run_commit(input bit [AW-1:0] last, input bit [PB-1:0] mask, input bit inject);
    int n = 0, bad_wr = 0, bad_ack = 0;
    for (int i = 0; i < PB; i++) pbuf[i] = 8'($urandom);
    for (int i = 0; i < PB; i++)
      if (mask[i]) exp_mem[(last & ~12'd31) | i] = pbuf[i];
    exp_cur = exp_after_write(last);
    commit_req = 1; commit_last = last; commit_mask = mask;
    @(negedge clk);
    commit_req = 0;
    chk(busy === 1'b1, "R1 busy after commit", busy, 1);
    while (busy === 1'b1 && n < CYC + 5) begin
      if (mem_we === 1'b1) begin
        got_mem[mem_addr] = mem_wdata;
        if (mem_addr !== ((last & ~12'd31) | n) || !mask[n] || mem_wdata !== pbuf[n]) bad_wr++;
      end else if (n < PB && mask[n]) bad_wr++;
      if (n >= PB && mem_we !== 1'b0) bad_wr++;
      if (ack_en !== 1'b0) bad_ack++;
      if (inject && n == 3) begin
        commit_req = 1; commit_last = ~last; commit_mask = '1;
        rd_done = 1; rd_addr = 12'h0AB; addr_load = 1; addr_load_val = 12'h5A5;
      end else begin
        commit_req = 0; rd_done = 0; addr_load = 0;
      end
      n++;
      @(negedge clk);
    end
    commit_req = 0; rd_done = 0; addr_load = 0;
    chk(n == CYC, "R2 busy length", n, CYC);
    chk(bad_wr == 0, "R4 write sequence errors", bad_wr, 0);
    chk(bad_ack == 0 && ack_en === 1'b1, "R3 ack gating", bad_ack, 0);
    chk(cur_addr === exp_cur, inject ? "R9 R7 cur_addr after cycle" : "R7 cur_addr after write",
        cur_addr, exp_cur);
    for (int i = 0; i < PB; i++) begin
      int a = (last & ~12'd31) | i;
      if (got_mem[a] !== exp_mem[a])
        chk(0, "R4 array content", got_mem[a], exp_mem[a]);
    end
    @(negedge clk);
    if (inject) chk(busy === 1'b0 && mem_we === 1'b0, "R5 no second cycle", busy, 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd90210);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0, "R10 busy reset", busy, 0);
    chk(ack_en === 1'b1, "R10 ack_en reset", ack_en, 1);
    chk(mem_we === 1'b0, "R10 mem_we reset", mem_we, 0);
    chk(cur_addr === 12'h000, "R10 cur_addr reset", cur_addr, 0);

    addr_load = 1; addr_load_val = 12'h123;
    @(negedge clk); addr_load = 0;
    chk(cur_addr === 12'h123, "R8 address load", cur_addr, 12'h123);

    rd_done = 1; rd_addr = 12'hFFF;
    @(negedge clk); rd_done = 0;
    chk(cur_addr === 12'h000, "R6 read wrap at top", cur_addr, 0);

    for (int k = 0; k < 3; k++) begin
      bit [AW-1:0] ra = 12'($urandom);
      rd_done = 1; rd_addr = ra;
      @(negedge clk); rd_done = 0;
      chk(cur_addr === exp_after_read(ra), "R6 read step", cur_addr, exp_after_read(ra));
    end

    addr_load = 1; addr_load_val = 12'h3C0; rd_done = 1; rd_addr = 12'h010;
    @(negedge clk); addr_load = 0; rd_done = 0;
    chk(cur_addr === 12'h3C0, "R8 load beats read", cur_addr, 12'h3C0);

    run_commit(12'h0BF, '1, 1'b1);
    run_commit(12'h7E5, 32'h0000_0021, 1'b0);
    run_commit(12'h400, '0, 1'b0);
    for (int k = 0; k < 8; k++)
      run_commit(12'($urandom), 32'($urandom), k[0]);

    commit_req = 1; commit_last = 12'hA1F; commit_mask = 32'h1;
    addr_load = 1; addr_load_val = 12'h777;
    @(negedge clk); commit_req = 0; addr_load = 0;
    chk(cur_addr === 12'hA00, "R8 commit beats load", cur_addr, 12'hA00);
    while (busy === 1'b1) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule